// File: doc/BRIEF.md
# Reference Selection Holdover Controller

This block is the control state machine of a dual-reference clock synchroniser. It tells the downstream timing loop two things. The first is which reference to follow, primary or secondary. The second is how to run: tracking that reference (normal), holding the last frequency it learned (holdover), or running on its own oscillator (freerun). The phase detector, loop filter and clock synthesis sit outside the block.

All control inputs are asynchronous to the system clock. They are sampled only when the 8 kHz frame strobe rises. The strobe passes through a two-flop synchroniser and an edge detector, which produce a one-cycle capture enable. The captured controls drive the state machine one cycle later.

In manual operation the two mode-select bits choose normal, holdover or freerun directly, and the source-select bit chooses the reference. In automatic operation the state machine moves on its own from the captured primary loss, secondary loss and guard-time inputs. The guard-time input qualifies only the moves out of primary holdover. A registered copy of the primary loss input is sent out as the guard-time output, which is normally fed back to the guard-time input through an RC delay.

States: `ST_PRI_NORM` (automatic, tracking primary), `ST_PRI_HOLD` (automatic, holdover on primary), `ST_SEC_NORM` (automatic, tracking secondary), `ST_SEC_HOLD` (automatic, holdover on secondary), `ST_MAN_NORM`, `ST_MAN_HOLD` and `ST_MAN_FREE` (manual). Automatic transitions:
- PRI_NORM to PRI_HOLD on primary loss.
- PRI_HOLD to PRI_NORM on guard high with the primary good.
- PRI_HOLD to SEC_NORM on guard high with the primary lost and the secondary good.
- SEC_NORM to PRI_NORM on primary restored.
- SEC_NORM to SEC_HOLD on secondary loss while the primary is still lost.
- SEC_HOLD to PRI_NORM on primary restored.
- SEC_HOLD to SEC_NORM on secondary restored.
- Any manual state to PRI_NORM when automatic operation is selected.
- Any state to the manual state named by the mode bits when manual operation is selected.

Top module: `refsel_ctrl`

## Requirements
- R1: Control inputs take effect only through a rising edge of `frame_strobe`. Input changes made while the strobe stays constant leave every output unchanged.
- R2: The captured `mode_sel` picks the operation. 2'b00 is manual normal, 2'b01 is manual holdover, 2'b10 is manual freerun and 2'b11 is automatic.
- R3: In manual operation `ref_sel` equals the captured `src_sel` (0 = primary, 1 = secondary), and `op_mode` is 2'b00, 2'b01 or 2'b10 for normal, holdover or freerun.
- R4: `mode_err` is high exactly while the captured mode is automatic and the captured `src_sel` is 1.
- R5: In automatic operation, a captured primary loss (`pri_los` = 1) moves PRI_NORM to PRI_HOLD.
- R6: From PRI_HOLD with guard high, a good primary leads to PRI_NORM, and a lost primary with a good secondary leads to SEC_NORM. With guard low the state stays in PRI_HOLD.
- R7: SEC_NORM returns to PRI_NORM when the primary is restored and goes to SEC_HOLD when the secondary is lost. SEC_HOLD goes to PRI_NORM when the primary is restored, or else to SEC_NORM when the secondary is restored. The guard input plays no part in these moves.
- R8: Selecting automatic operation from any manual state enters PRI_NORM.
- R9: `guard_out` equals the `pri_los` value captured at the last strobe edge, and it is high while `rst_n` is low.
- R10: After reset, before any strobe edge, the block is in PRI_NORM with `op_mode` = 2'b00, `ref_sel` = 0 and `mode_err` = 0. `op_mode` never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the frame strobe |
| rst_n | input | 1 | Active-low reset |
| frame_strobe | input | 1 | 8 kHz frame strobe, asynchronous |
| pri_los | input | 1 | Primary reference lost when 1 |
| sec_los | input | 1 | Secondary reference lost when 1 |
| guard_in | input | 1 | Guard-time input |
| mode_sel | input | 2 | Operation and manual state select |
| src_sel | input | 1 | Manual reference select |
| op_mode | output | 2 | 00 normal, 01 holdover, 10 freerun |
| ref_sel | output | 1 | 0 primary, 1 secondary |
| guard_out | output | 1 | Registered primary loss |
| mode_err | output | 1 | Source select high in automatic operation |

## Verification
Count clock edges from the first edge that sees `frame_strobe` high:
- The edge detector fires after the second edge.
- `guard_out`, `mode_err` and a manual `ref_sel` change at the third edge.
- The state, and so `op_mode` and the automatic `ref_sel`, change at the fourth edge.

The bench raises the strobe at a falling clock edge. It lets four rising edges pass and samples at the next falling edge, where every result of that strobe is settled. Before the next strobe it lowers the strobe for four more edges. For the hold checks it waits several cycles without any strobe and then compares the outputs with their previous values.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [2:0] {
        ST_PRI_NORM = 3'd0,
        ST_PRI_HOLD = 3'd1,
        ST_SEC_NORM = 3'd2,
        ST_SEC_HOLD = 3'd3,
        ST_MAN_NORM = 3'd4,
        ST_MAN_HOLD = 3'd5,
        ST_MAN_FREE = 3'd6
    } st_t;

    localparam logic [1:0] OPM_NORMAL = 2'b00;
    localparam logic [1:0] OPM_HOLD   = 2'b01;
    localparam logic [1:0] OPM_FREE   = 2'b10;

    localparam logic [1:0] MSEL_NORM  = 2'b00;
    localparam logic [1:0] MSEL_HOLD  = 2'b01;
    localparam logic [1:0] MSEL_FREE  = 2'b10;
    localparam logic [1:0] MSEL_AUTO  = 2'b11;

    typedef struct packed {
        logic       pri_lost;
        logic       sec_lost;
        logic       guard;
        logic [1:0] msel;
        logic       src;
    } ctl_t;

endpackage

// File: rtl/refsel_strobe_sync.sv
module refsel_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], strobe_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/refsel_capture.sv
module refsel_capture
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  ctl_t       ctl_in,
    output ctl_t       ctl_q,
    output logic       step
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.msel     <= MSEL_AUTO;
            step           <= 1'b0;
        end else begin
            step <= cap_en;
            if (cap_en) begin
                ctl_q <= ctl_in;
            end
        end
    end

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  ctl_t       ctl,
    output st_t        state,
    output logic [1:0] op_mode,
    output logic       ref_sel
);
    st_t nxt;

    always_comb begin
        nxt = state;
        if (ctl.msel != MSEL_AUTO) begin
            unique case (ctl.msel)
                MSEL_NORM: nxt = ST_MAN_NORM;
                MSEL_HOLD: nxt = ST_MAN_HOLD;
                default:   nxt = ST_MAN_FREE;
            endcase
        end else begin
            unique case (state)
                ST_PRI_NORM: begin
                    if (ctl.pri_lost) nxt = ST_PRI_HOLD;
                end
                ST_PRI_HOLD: begin
                    if (ctl.guard && !ctl.pri_lost) begin
                        nxt = ST_PRI_NORM;
                    end else if (ctl.guard && !ctl.sec_lost) begin
                        nxt = ST_SEC_NORM;
                    end
                end
                ST_SEC_NORM: begin
                    if (!ctl.pri_lost)     nxt = ST_PRI_NORM;
                    else if (ctl.sec_lost) nxt = ST_SEC_HOLD;
                end
                ST_SEC_HOLD: begin
                    if (!ctl.pri_lost)      nxt = ST_PRI_NORM;
                    else if (!ctl.sec_lost) nxt = ST_SEC_NORM;
                end
                default: nxt = ST_PRI_NORM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PRI_NORM;
        end else if (step) begin
            state <= nxt;
        end
    end

    always_comb begin
        op_mode = OPM_NORMAL;
        ref_sel = 1'b0;
        unique case (state)
            ST_PRI_NORM: begin op_mode = OPM_NORMAL; ref_sel = 1'b0;    end
            ST_PRI_HOLD: begin op_mode = OPM_HOLD;   ref_sel = 1'b0;    end
            ST_SEC_NORM: begin op_mode = OPM_NORMAL; ref_sel = 1'b1;    end
            ST_SEC_HOLD: begin op_mode = OPM_HOLD;   ref_sel = 1'b1;    end
            ST_MAN_NORM: begin op_mode = OPM_NORMAL; ref_sel = ctl.src; end
            ST_MAN_HOLD: begin op_mode = OPM_HOLD;   ref_sel = ctl.src; end
            default:     begin op_mode = OPM_FREE;   ref_sel = ctl.src; end
        endcase
    end

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_strobe,
    input  logic       pri_los,
    input  logic       sec_los,
    input  logic       guard_in,
    input  logic [1:0] mode_sel,
    input  logic       src_sel,
    output logic [1:0] op_mode,
    output logic       ref_sel,
    output logic       guard_out,
    output logic       mode_err
);
    logic cap_en;
    logic fsm_en;
    ctl_t ctl_raw;
    ctl_t ctl_q;
    st_t  st;
    logic cap_auto;

    assign ctl_raw = '{pri_lost: pri_los, sec_lost: sec_los, guard: guard_in,
                       msel: mode_sel, src: src_sel};

    refsel_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (frame_strobe),
        .rise      (cap_en)
    );

    refsel_capture cap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .ctl_in (ctl_raw),
        .ctl_q  (ctl_q),
        .step   (fsm_en)
    );

    refsel_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (fsm_en),
        .ctl     (ctl_q),
        .state   (st),
        .op_mode (op_mode),
        .ref_sel (ref_sel)
    );

    assign cap_auto  = (ctl_q.msel == MSEL_AUTO);
    assign mode_err  = cap_auto & ctl_q.src;
    assign guard_out = rst_n ? ctl_q.pri_lost : 1'b1;

endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk
    import refsel_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pri_los,
    input logic [1:0] op_mode,
    input logic       ref_sel,
    input logic       guard_out,
    input logic       mode_err,
    input logic       cap_en,
    input logic       fsm_en,
    input logic       cap_auto,
    input st_t        st,
    input ctl_t       ctl_q
);
    // R1: without a capture or step in the previous cycle the outputs hold
    p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cap_en) && !$past(fsm_en)) |-> ($stable(op_mode) && $stable(ref_sel)));

    // R4: the error flag can only rise right after a capture
    p_err_on_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err) |-> $past(cap_en));

    // R5: primary loss leaves primary normal
    p_pri_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_en && cap_auto && st == ST_PRI_NORM && ctl_q.pri_lost)
        |=> (op_mode == OPM_HOLD && !ref_sel));

    // R6: guard low keeps primary holdover
    p_guard_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_en && cap_auto && st == ST_PRI_HOLD && !ctl_q.guard)
        |=> (st == ST_PRI_HOLD));

    // R9: guard output follows the primary loss value present at capture
    p_guard_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (guard_out == $past(pri_los)));

    // R10: no illegal mode code
    p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode != 2'b11);

endmodule

bind refsel_ctrl refsel_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_los   (pri_los),
    .op_mode   (op_mode),
    .ref_sel   (ref_sel),
    .guard_out (guard_out),
    .mode_err  (mode_err),
    .cap_en    (cap_en),
    .fsm_en    (fsm_en),
    .cap_auto  (cap_auto),
    .st        (st),
    .ctl_q     (ctl_q)
);

// File: tb/refsel_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsel_ctrl_tb_top;
    localparam int PN = 0, PH = 1, SN = 2, SH = 3, MN = 4, MH = 5, MF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b0;
    logic       pri_los = 1'b0;
    logic       sec_los = 1'b0;
    logic       guard_in = 1'b0;
    logic [1:0] mode_sel = 2'b11;
    logic       src_sel = 1'b0;
    logic [1:0] op_mode;
    logic       ref_sel;
    logic       guard_out;
    logic       mode_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_st = PN;
    logic m_src = 1'b0;
    logic m_auto = 1'b1;
    logic m_pri = 1'b0;

    always #2.5 clk = ~clk;

    refsel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .pri_los(pri_los), .sec_los(sec_los), .guard_in(guard_in),
        .mode_sel(mode_sel), .src_sel(src_sel),
        .op_mode(op_mode), .ref_sel(ref_sel),
        .guard_out(guard_out), .mode_err(mode_err)
    );

    function automatic int next_st(int cur, logic [1:0] ms, logic pl, logic sl, logic g);
        if (ms == 2'b00) return MN;
        if (ms == 2'b01) return MH;
        if (ms == 2'b10) return MF;
        case (cur)
            PN: return pl ? PH : PN;
            PH: begin
                if (g && !pl) return PN;
                if (g && !sl) return SN;
                return PH;
            end
            SN: begin
                if (!pl) return PN;
                if (sl)  return SH;
                return SN;
            end
            SH: begin
                if (!pl) return PN;
                if (!sl) return SN;
                return SH;
            end
            default: return PN;
        endcase
    endfunction

    function automatic logic [1:0] exp_mode(int s);
        if (s == PH || s == SH || s == MH) return 2'b01;
        if (s == MF) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic exp_ref(int s, logic src);
        if (s == SN || s == SH) return 1'b1;
        if (s >= MN) return src;
        return 1'b0;
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk({req, " op_mode"},   {2'b0, op_mode},   {2'b0, exp_mode(m_st)});
        chk({req, " ref_sel"},   {3'b0, ref_sel},   {3'b0, exp_ref(m_st, m_src)});
        chk({req, " guard_out"}, {3'b0, guard_out}, {3'b0, m_pri});
        chk({req, " mode_err"},  {3'b0, mode_err},  {3'b0, m_auto & m_src});
    endtask

    task automatic strobe(logic [1:0] ms, logic src, logic pl, logic sl, logic g, string req);
        @(negedge clk);
        mode_sel = ms; src_sel = src; pri_los = pl; sec_los = sl; guard_in = g;
        frame_strobe = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        m_st = next_st(m_st, ms, pl, sl, g);
        m_src = src; m_auto = (ms == 2'b11); m_pri = pl;
        check_all(req);
        frame_strobe = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0] hold_mode;
        logic       hold_ref;
        logic       hold_g;
        repeat (3) @(negedge clk);
        chk("R9 guard high in reset", {3'b0, guard_out}, 4'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R10 reset state");

        strobe(2'b11, 0, 1, 0, 0, "R5 pri loss");
        strobe(2'b11, 0, 1, 0, 0, "R6 guard low stays");
        strobe(2'b11, 0, 0, 0, 0, "R6 guard low pri back stays");
        strobe(2'b11, 0, 1, 0, 1, "R6 guard to secondary");
        strobe(2'b11, 0, 1, 1, 0, "R7 sec loss");
        strobe(2'b11, 0, 1, 0, 0, "R7 sec restored");
        strobe(2'b11, 0, 0, 0, 0, "R7 pri restored");
        strobe(2'b11, 0, 1, 0, 0, "R5 pri loss again");
        strobe(2'b11, 0, 0, 0, 1, "R6 guard to primary");
        strobe(2'b11, 1, 0, 0, 0, "R4 mode error");
        strobe(2'b10, 1, 0, 0, 0, "R2 R3 manual freerun");
        strobe(2'b01, 0, 1, 1, 1, "R2 R3 manual holdover");
        strobe(2'b00, 1, 0, 1, 0, "R2 R3 manual normal");
        strobe(2'b11, 0, 1, 1, 1, "R8 manual to auto");

        // R1: toggle everything without a strobe edge
        hold_mode = op_mode; hold_ref = ref_sel; hold_g = guard_out;
        @(negedge clk);
        mode_sel = 2'b10; src_sel = 1; pri_los = 0; sec_los = 1; guard_in = 1;
        repeat (8) @(negedge clk);
        chk("R1 no strobe op_mode", {2'b0, op_mode}, {2'b0, hold_mode});
        chk("R1 no strobe ref_sel", {3'b0, ref_sel}, {3'b0, hold_ref});
        chk("R1 no strobe guard_out", {3'b0, guard_out}, {3'b0, hold_g});

        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            logic [1:0] ms;
            logic src;
            ms  = ($urandom % 5 == 0) ? 2'($urandom % 3) : 2'b11;
            src = ($urandom % 6 == 0);
            strobe(ms, src, 1'($urandom), 1'($urandom), 1'($urandom),
                   "R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule